// File: doc/BRIEF.md
# Multi-Size Logical Left Shift Unit

This unit shifts a 32-bit register value left by a small fixed amount at one of three operand sizes: byte (low 8 bits), word (low 16 bits) or long (all 32 bits). It fills the vacated low bits with zeros. For the narrow sizes, only the low lane changes and the register's upper bits pass through untouched. It also produces the five condition flags (half-carry, negative, zero, overflow, carry) that a small CPU datapath expects. The carry flag is the last bit that leaves the top of the sized operand.

The set of legal shift amounts depends on the operand size and on the CPU variant the datapath is configured as. A request outside that set does not update the register result or the flags. It raises an illegal indication instead.

A request is captured on a valid strobe. The merged register value, the flags and a done pulse appear on the next clock. Requests may arrive back to back, one per cycle.

Top module: `shl_unit`

## Requirements
- R1: `count_i` is a code c that selects a shift by 2^c. Codes 0 to 4 give 1, 2, 4, 8 and 16 places. Codes 5, 6 and 7 are always illegal.
- R2: `size_i` encodes 0 = byte, 1 = word, 2 = long and 3 = reserved. A reserved size is always illegal. A byte shift by 1, 2 or 4 is legal in every variant, and a byte shift by 8 or 16 is illegal.
- R3: In variant 0 (`variant_i` = 0, the basic variant), every word and long request is illegal.
- R4: Word and long shifts by 1 or 2 are legal in variants 1, 2 and 3. Word shifts by 4 or 8 and long shifts by 4, 8 or 16 are legal only in variant 3. A word shift by 16 is always illegal.
- R5: A legal request sets the sized lane of `result_o` to the lane of `data_i` shifted left with zero fill. The bits of `data_i` above the lane appear unchanged.
- R6: After a legal request, the carry flag `flags_o[0]` equals the last bit shifted out of the top of the sized operand, that is, operand bit (width − shift).
- R7: After a legal request, the negative flag `flags_o[3]` equals the top bit of the sized result. The zero flag `flags_o[2]` is 1 exactly when the sized result is all zeros.
- R8: After a legal request, the half-carry flag `flags_o[4]` and the overflow flag `flags_o[1]` are 0.
- R9: An illegal request pulses `illegal_o` together with `done_o`. `result_o` and `flags_o` keep their previous values.
- R10: `done_o` is 1 in the cycle after each cycle with `valid_i` high, and 0 otherwise. `illegal_o` is 0 whenever `done_o` is 0.
- R11: A synchronous, active-high `rst` sets `result_o`, `flags_o`, `done_o` and `illegal_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Request strobe |
| size_i | input | 2 | Operand size code |
| count_i | input | 3 | Shift count code (shift by 2^code) |
| variant_i | input | 2 | CPU variant, 0 = basic, 3 = most extended |
| data_i | input | 32 | Register value to shift |
| result_o | output | 32 | Merged register result |
| flags_o | output | 5 | {H, N, Z, V, C} |
| done_o | output | 1 | Result valid pulse |
| illegal_o | output | 1 | Request was an illegal combination |

## Verification
A new result and a held result can land in adjacent cycles. This happens when the legality check rejects one request and a legal request arrives in the very next cycle, or the other way round. The bench keeps the strobe high through an exhaustive sweep of every size, count code and variant over several data patterns, so legal and illegal requests interleave one per cycle. Each cycle is judged against an arithmetic model that recomputes the expected result and flags, and that holds the previous expected value across rejected requests.

// File: rtl/shl_pkg.sv
package shl_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_LANES = 3;
  localparam int unsigned CNT_W     = 3;
  localparam int unsigned VAR_W     = 2;
  localparam int unsigned AMT_W     = 5;
  localparam int unsigned MAX_CODE  = 4;
  localparam int unsigned FLAG_W    = 5;

  localparam logic [VAR_W-1:0] VAR_BASIC = '0;
  localparam logic [VAR_W-1:0] VAR_FULL  = '1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } op_size_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic int unsigned lane_width(int unsigned g);
    return DATA_W >> (NUM_LANES - 1 - g);
  endfunction

  function automatic int unsigned size_lane(op_size_e s);
    case (s)
      SZ_BYTE: return 0;
      SZ_WORD: return 1;
      default: return NUM_LANES - 1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(int unsigned g);
    logic [DATA_W:0] one_ext;
    one_ext = (DATA_W+1)'(1) << lane_width(g);
    return one_ext[DATA_W-1:0] - DATA_W'(1);
  endfunction

  function automatic logic [AMT_W-1:0] code_to_amt(logic [CNT_W-1:0] code);
    if (code > CNT_W'(MAX_CODE)) return '0;
    return AMT_W'(1) << code;
  endfunction

endpackage

// File: rtl/shl_legal_chk.sv
module shl_legal_chk
  import shl_pkg::*;
(
  input  op_size_e          size_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [VAR_W-1:0]  variant_i,
  output logic              legal_o,
  output logic [AMT_W-1:0]  amt_o
);

  logic code_ok;
  logic basic_only;
  logic full_only;

  assign code_ok  = (count_i <= CNT_W'(MAX_CODE));
  assign amt_o    = code_to_amt(count_i);
  // Counts 1 and 2 need only a non-basic variant; larger ones need the full variant.
  assign basic_only = (count_i <= CNT_W'(1));
  assign full_only  = (variant_i == VAR_FULL);

  always_comb begin
    legal_o = 1'b0;
    if (code_ok) begin
      case (size_i)
        SZ_BYTE: legal_o = (count_i <= CNT_W'(2));
        SZ_WORD: legal_o = (variant_i != VAR_BASIC) &&
                           (basic_only || (full_only && count_i <= CNT_W'(3)));
        SZ_LONG: legal_o = (variant_i != VAR_BASIC) &&
                           (basic_only || full_only);
        default: legal_o = 1'b0;
      endcase
    end
  end

  // R3: basic variant rejects anything wider than a byte
  always_comb begin
    if (variant_i == VAR_BASIC && (size_i == SZ_WORD || size_i == SZ_LONG))
      a_r3_basic_rejects_wide: assert (!legal_o);
  end

  // R1: reserved count codes never pass
  always_comb begin
    if (count_i > CNT_W'(MAX_CODE))
      a_r1_reserved_code: assert (!legal_o);
  end

endmodule

// File: rtl/shl_lane.sv
module shl_lane
  import shl_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]     opnd_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);

  logic [2*W-1:0] ext;

  assign ext     = {{W{1'b0}}, opnd_i} << amt_i;
  assign res_o   = ext[W-1:0];
  // The bit just above the lane is the last one pushed out of the operand.
  assign carry_o = ext[W];

endmodule

// File: rtl/shl_flag_gen.sv
module shl_flag_gen
  import shl_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  op_size_e          size_i,
  input  logic [DATA_W-1:0] lane_res_i [NUM_LANES],
  input  logic              lane_c_i   [NUM_LANES],
  output logic [DATA_W-1:0] merged_o,
  output flags_t            flags_o
);

  int unsigned       sel;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] sized;

  always_comb begin
    sel      = size_lane(size_i);
    mask     = lane_mask(sel);
    sized    = lane_res_i[sel] & mask;
    merged_o = (data_i & ~mask) | sized;
    flags_o.h = 1'b0;
    flags_o.v = 1'b0;
    flags_o.n = sized[lane_width(sel) - 1];
    flags_o.z = (sized == '0);
    flags_o.c = lane_c_i[sel];
  end

endmodule

// File: rtl/shl_unit.sv
module shl_unit
  import shl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [VAR_W-1:0]  variant_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              done_o,
  output logic              illegal_o
);

  op_size_e          size_e;
  logic              legal;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] lane_res [NUM_LANES];
  logic              lane_c   [NUM_LANES];
  logic [DATA_W-1:0] merged;
  flags_t            flags_next;
  logic              accept;
  logic              reject;

  assign size_e = op_size_e'(size_i);
  assign accept = valid_i && legal;
  assign reject = valid_i && !legal;

  shl_legal_chk u_legal (
    .size_i    (size_e),
    .count_i   (count_i),
    .variant_i (variant_i),
    .legal_o   (legal),
    .amt_o     (amt)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = lane_width(g);
    logic [LW-1:0] narrow;
    shl_lane #(.W(LW)) u_lane (
      .opnd_i  (data_i[LW-1:0]),
      .amt_i   (amt),
      .res_o   (narrow),
      .carry_o (lane_c[g])
    );
    assign lane_res[g] = DATA_W'(narrow);
  end

  shl_flag_gen u_flags (
    .data_i     (data_i),
    .size_i     (size_e),
    .lane_res_i (lane_res),
    .lane_c_i   (lane_c),
    .merged_o   (merged),
    .flags_o    (flags_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      flags_o   <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= valid_i;
      illegal_o <= reject;
      if (accept) begin
        result_o <= merged;
        flags_o  <= flags_next;
      end
    end
  end

  a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!done_o && !illegal_o));

  a_r9_hold_on_reject: assert property (@(posedge clk) disable iff (rst)
    reject |=> ($stable(result_o) && $stable(flags_o)));

  a_r5_upper_passthru: assert property (@(posedge clk) disable iff (rst)
    (accept && size_e == SZ_BYTE) |=> (result_o[DATA_W-1:8] == $past(data_i[DATA_W-1:8])));

  a_r5_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o) |-> (result_o[0] == 1'b0));

  a_r7_z_excludes_n: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o) |-> !(flags_o[2] && flags_o[3]));

  a_r8_h_v_clear: assert property (@(posedge clk) disable iff (rst)
    accept |=> (flags_o[4] == 1'b0 && flags_o[1] == 1'b0));

endmodule

// File: tb/shl_unit_tb.sv
`timescale 1ns/1ps
module shl_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [1:0]  size_i;
  logic [2:0]  count_i;
  logic [1:0]  variant_i;
  logic [31:0] data_i;
  logic [31:0] result_o;
  logic [4:0]  flags_o;
  logic        done_o;
  logic        illegal_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [31:0] exp_res   = '0;
  logic [4:0]  exp_flags = '0;

  always #2.5 clk = ~clk;

  shl_unit u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .size_i(size_i),
    .count_i(count_i), .variant_i(variant_i), .data_i(data_i),
    .result_o(result_o), .flags_o(flags_o), .done_o(done_o),
    .illegal_o(illegal_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (size %0d code %0d var %0d data %h)",
               req, what, act, exp, size_i, count_i, variant_i, data_i);
    end
  endtask

  function automatic bit model_legal(int s, int c, int v);
    if (c > 4 || s == 3) return 0;
    if (s == 0) return c <= 2;
    if (v == 0) return 0;
    if (c <= 1) return 1;
    return (v == 3) && (c <= s + 2);
  endfunction

  function automatic string legal_tag(int s, int c, int v);
    if (c > 4) return "R1";
    if (s == 3 || s == 0) return "R2";
    if (v == 0) return "R3";
    return "R4";
  endfunction

  // Drive one request at a falling edge and judge it at the next falling edge.
  task automatic run_op(input int s, input int c, input int v, input logic [31:0] d);
    longint unsigned w, k, mask, opnd, sh;
    bit lg, cy, nn, zz;
    valid_i = 1'b1; size_i = 2'(s); count_i = 3'(c); variant_i = 2'(v); data_i = d;
    lg = model_legal(s, c, v);
    if (lg) begin
      w    = 64'd8 << s;
      k    = 64'd1 << c;
      mask = (64'd1 << w) - 1;
      opnd = d & mask;
      sh   = (opnd * (64'd1 << k)) & mask;
      cy   = ((opnd >> (w - k)) & 1) != 0;
      nn   = ((sh >> (w - 1)) & 1) != 0;
      zz   = (sh == 0);
      exp_res   = 32'((longint'(d) & ~mask & 64'hFFFF_FFFF) | sh);
      exp_flags = {1'b0, nn, zz, 1'b0, cy};
    end
    @(negedge clk);
    check("R10", "done", 32'(done_o), 32'd1);
    check(lg ? "R9" : legal_tag(s, c, v), "illegal", 32'(illegal_o), 32'(!lg));
    check(lg ? "R5" : "R9", "result", result_o, exp_res);
    check(lg ? "R6" : "R9", "carry", 32'(flags_o[0]), 32'(exp_flags[0]));
    check(lg ? "R7" : "R9", "neg/zero", 32'(flags_o[3:2]), 32'(exp_flags[3:2]));
    check(lg ? "R8" : "R9", "half/ovf", 32'({flags_o[4], flags_o[1]}), 32'd0);
  endtask

  logic [31:0] pats [6] = '{32'hA5A5A5A5, 32'h00000000, 32'hFFFFFFFF,
                            32'h80008080, 32'h00010101, 32'h5A0F3CC3};

  initial begin
    rst = 1'b1; valid_i = 1'b0; size_i = '0; count_i = '0; variant_i = '0; data_i = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "result", result_o, 32'd0);
    check("R11", "flags", 32'(flags_o), 32'd0);
    check("R11", "done/illegal", 32'({done_o, illegal_o}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", "idle done", 32'(done_o), 32'd0);

    // Spot cases: byte A5 by 1 and by 4, word by 8, long by 16
    run_op(0, 0, 0, 32'hA5A5A5A5);
    check("R6", "byte A5<<1 result", result_o, 32'hA5A5A54A);
    run_op(0, 2, 0, 32'hA5A5A5A5);
    check("R5", "byte A5<<4 result", result_o, 32'hA5A5A550);
    run_op(1, 3, 3, 32'hA5A5A5A5);
    check("R6", "word <<8", {result_o[31:1], flags_o[0]}, {31'h52D2D280, 1'b1});
    run_op(2, 4, 1, 32'h12345678);
    check("R4", "long <<16 held in variant 1", 32'(illegal_o), 32'd1);
    run_op(2, 4, 3, 32'hA5A5A5A5);
    check("R7", "long <<16 N", {result_o[31:1], flags_o[3]}, {31'h52D28000, 1'b1});

    // Back-to-back exhaustive sweep
    foreach (pats[p]) begin
      for (int v = 0; v < 4; v++)
        for (int s = 0; s < 4; s++)
          for (int c = 0; c < 8; c++)
            run_op(s, c, v, pats[p] ^ 32'(v * 32'h01010101 + c));
    end

    // Idle gap: no done, outputs held
    valid_i = 1'b0;
    @(negedge clk);
    check("R10", "gap done", 32'({done_o, illegal_o}), 32'd0);
    check("R10", "gap result", result_o, exp_res);

    // Mid-run reset
    run_op(2, 1, 2, 32'h0F0F0F0F);
    valid_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R11", "reset result", result_o, 32'd0);
    check("R11", "reset flags", 32'(flags_o), 32'd0);
    rst = 1'b0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule